// File: doc/BRIEF.md
# Boot-Mode Address Decoder and Interrupt Gate

This block sits between a 16-bit CPU and the on-board resources of a processor card. It decodes the 24-bit byte address of each bus cycle into one select line per resource: on-board RAM, a primary and a secondary PROM, the serial controller, the timer, the page map, the segment map, the context register (write side) and a fixed status word (read side). An address that matches nothing raises a miss flag, so the bus logic can signal a bus error. The memories, the peripherals and the translation logic are outside this block.

After reset the card is in boot mode. In boot mode the primary PROM image shows through in the low 256 KiB, address translation is off, and the seven interrupt request lines are held back from the CPU. The first write to the primary PROM's own window ends boot mode. That write also stores its data bit 0 as the parity-enable setting, and the requests that are pending at that moment reach the CPU on the next cycle. Writes to that window after boot mode has ended still update parity enable.

Top module: `brd_boot_decoder`

## Requirements
- R1: Reset puts the block in boot mode. While reset is held and after it is released, bootMode=1, mmuEnable=0, parityEn=0 and irqOut=0, and these hold until the first write to the primary PROM window.
- R2: Outside boot mode, addresses 0x000000–0x03FFFF select RAM (selOut bit 0). Addresses 0x040000–0x1FFFFF raise decodeMiss, in boot mode and outside it.
- R3: In boot mode, every address in 0x000000–0x03FFFF selects the primary PROM (selOut bit 1) and not RAM.
- R4: Addresses 0x200000–0x23FFFF select the primary PROM (bit 1) and 0x400000–0x43FFFF select the secondary PROM (bit 2), in either mode. The rest of 0x240000–0x3FFFFF and 0x440000–0x5FFFFF raise decodeMiss.
- R5: Any address in 0x600000–0x7FFFFF selects the serial controller (bit 3). Any address in 0x800000–0x9FFFFF selects the timer (bit 4).
- R6: 0xA00000–0xBFFFFF selects the page map (bit 5). 0xC00000–0xDFFFFF selects the segment map (bit 6).
- R7: In 0xE00000–0xFFFFFF a write selects the context register (bit 7). A read selects the status word (bit 8) and drives statusData=0x1FFF. statusData is 0 in every other cycle.
- R8: With busValid=0, selOut=0 and decodeMiss=0. With busValid=1, exactly one of selOut's nine bits or decodeMiss is set.
- R9: A write in 0x200000–0x23FFFF loads wrLsb into parityEn at the clock edge. If bootMode is set, the same write clears it and sets mmuEnable. Reads in that window change neither. Boot mode is entered again only through reset.
- R10: In boot mode, a write in 0x000000–0x03FFFF selects the primary PROM but leaves bootMode and parityEn unchanged.
- R11: In boot mode, irqOut=0 whatever irqReq is. Outside boot mode, irqOut equals the irqReq sampled at the previous rising edge. This includes requests already pending when boot mode ends, which appear in the cycle after the ending write.
- R12: winOffset always equals the low 18 address bits, the byte offset inside a 256 KiB window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busValid | input | 1 | A bus cycle is in progress |
| busWrite | input | 1 | 1 = write cycle, 0 = read cycle |
| addr | input | 24 | Byte address |
| wrLsb | input | 1 | Data bit 0 of the write |
| irqReq | input | 7 | Interrupt requests from the sources |
| selOut | output | 9 | One-hot resource select (bit map in R2–R7) |
| decodeMiss | output | 1 | The address matches no resource |
| winOffset | output | 18 | Offset inside the selected window |
| statusData | output | 16 | Read data of the status word |
| bootMode | output | 1 | Boot mode is active |
| mmuEnable | output | 1 | Address translation is enabled |
| parityEn | output | 1 | Parity-enable setting |
| irqOut | output | 7 | Interrupt requests passed on to the CPU |

## Verification
The bench builds the block with the default parameters: a 24-bit address, 2 MiB regions, 256 KiB windows and seven interrupt lines. With these values every region edge, and the first address past each window, can be reached with literal addresses. The bench checks these edges in boot mode and again after boot mode ends. This covers the swap between the PROM overlay and RAM, writes to the low overlay that must not end boot mode, requests held during boot that come out one cycle after the ending write, and a reset in the middle of the run that brings boot mode back.

// File: rtl/brd_pkg.sv
`timescale 1ns/1ps
package brd_pkg;
  localparam int SEL_N      = 9;
  localparam int SEL_RAM    = 0;
  localparam int SEL_PROM0  = 1;
  localparam int SEL_PROM1  = 2;
  localparam int SEL_SERIAL = 3;
  localparam int SEL_TIMER  = 4;
  localparam int SEL_PAGE   = 5;
  localparam int SEL_SEG    = 6;
  localparam int SEL_CTX    = 7;
  localparam int SEL_STAT   = 8;

  // control -> datapath strobes
  typedef struct packed {
    logic overlayOn;
    logic irqPass;
  } ctrlStrb_t;

  // datapath -> control strobes
  typedef struct packed {
    logic romWrite;
  } dpStrb_t;
endpackage

// File: rtl/brd_datapath.sv
`timescale 1ns/1ps
module brd_datapath
  import brd_pkg::*;
#(
  parameter int ADDR_W      = 24,
  parameter int REGION_LOG2 = 21,
  parameter int WIN_LOG2    = 18,
  parameter int IRQ_N       = 7,
  parameter logic [15:0] STATUS_VAL = 16'h1FFF
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      busValid,
  input  logic                      busWrite,
  input  logic [ADDR_W-1:WIN_LOG2]  addrHi,
  input  logic [IRQ_N-1:0]          irqReq,
  input  ctrlStrb_t                 ctl,
  output dpStrb_t                   dp,
  output logic [SEL_N-1:0]          sel,
  output logic                      miss,
  output logic [15:0]               statusData,
  output logic [IRQ_N-1:0]          irqOut
);
  localparam int REG_W = ADDR_W - REGION_LOG2;

  logic [REG_W-1:0] region;
  logic             inWin;
  logic [IRQ_N-1:0] irqHold;

  assign region = addrHi[ADDR_W-1:REGION_LOG2];
  assign inWin  = (addrHi[REGION_LOG2-1:WIN_LOG2] == '0);

  always_comb begin
    sel  = '0;
    miss = 1'b0;
    if (busValid) begin
      case (int'(region))
        0: if (inWin) sel[ctl.overlayOn ? SEL_PROM0 : SEL_RAM] = 1'b1;
           else miss = 1'b1;
        1: if (inWin) sel[SEL_PROM0] = 1'b1; else miss = 1'b1;
        2: if (inWin) sel[SEL_PROM1] = 1'b1; else miss = 1'b1;
        3: sel[SEL_SERIAL] = 1'b1;
        4: sel[SEL_TIMER]  = 1'b1;
        5: sel[SEL_PAGE]   = 1'b1;
        6: sel[SEL_SEG]    = 1'b1;
        7: sel[busWrite ? SEL_CTX : SEL_STAT] = 1'b1;
        default: miss = 1'b1;
      endcase
    end
  end

  assign statusData  = sel[SEL_STAT] ? STATUS_VAL : 16'h0000;
  assign dp.romWrite = busValid && busWrite && inWin && (int'(region) == 1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) irqHold <= '0;
    else       irqHold <= irqReq;
  end

  assign irqOut = ctl.irqPass ? irqHold : '0;

  a_r8_onehot: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(sel));
  a_r8_miss_excl: assert property (@(posedge clk) disable iff (!rstN)
    miss |-> (sel == '0));
  a_r8_idle: assert property (@(posedge clk) disable iff (!rstN)
    !busValid |-> (sel == '0 && !miss));
  a_r11_boot_hold: assert property (@(posedge clk) disable iff (!rstN)
    ctl.overlayOn |-> (irqOut == '0));
  a_r11_pass: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.irqPass && $past(ctl.irqPass)) |-> (irqOut == $past(irqReq)));
endmodule

// File: rtl/brd_ctrl.sv
`timescale 1ns/1ps
module brd_ctrl
  import brd_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  dpStrb_t   dp,
  input  logic      wrLsb,
  output ctrlStrb_t ctl,
  output logic      bootMode,
  output logic      parityEn
);
  logic bootQ;
  logic parityQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bootQ   <= 1'b1;
      parityQ <= 1'b0;
    end else if (dp.romWrite) begin
      bootQ   <= 1'b0;
      parityQ <= wrLsb;
    end
  end

  assign ctl.overlayOn = bootQ;
  assign ctl.irqPass   = !bootQ;
  assign bootMode      = bootQ;
  assign parityEn      = parityQ;

  a_r9_exit: assert property (@(posedge clk) disable iff (!rstN)
    dp.romWrite |=> (!bootQ && parityQ == $past(wrLsb)));
  a_r9_no_reentry: assert property (@(posedge clk) disable iff (!rstN)
    !bootQ |=> !bootQ);
  a_r10_par_hold: assert property (@(posedge clk) disable iff (!rstN)
    !dp.romWrite |=> ($stable(parityQ) && $stable(bootQ)));
endmodule

// File: rtl/brd_boot_decoder.sv
`timescale 1ns/1ps
module brd_boot_decoder
  import brd_pkg::*;
#(
  parameter int ADDR_W      = 24,
  parameter int REGION_LOG2 = 21,
  parameter int WIN_LOG2    = 18,
  parameter int IRQ_N       = 7,
  parameter logic [15:0] STATUS_VAL = 16'h1FFF
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                busValid,
  input  logic                busWrite,
  input  logic [ADDR_W-1:0]   addr,
  input  logic                wrLsb,
  input  logic [IRQ_N-1:0]    irqReq,
  output logic [8:0]          selOut,
  output logic                decodeMiss,
  output logic [WIN_LOG2-1:0] winOffset,
  output logic [15:0]         statusData,
  output logic                bootMode,
  output logic                mmuEnable,
  output logic                parityEn,
  output logic [IRQ_N-1:0]    irqOut
);
  ctrlStrb_t ctl;
  dpStrb_t   dp;

  brd_datapath #(
    .ADDR_W(ADDR_W), .REGION_LOG2(REGION_LOG2), .WIN_LOG2(WIN_LOG2),
    .IRQ_N(IRQ_N), .STATUS_VAL(STATUS_VAL)
  ) u_dp (
    .clk(clk), .rstN(rstN), .busValid(busValid), .busWrite(busWrite),
    .addrHi(addr[ADDR_W-1:WIN_LOG2]), .irqReq(irqReq), .ctl(ctl), .dp(dp),
    .sel(selOut), .miss(decodeMiss), .statusData(statusData), .irqOut(irqOut)
  );

  brd_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .dp(dp), .wrLsb(wrLsb), .ctl(ctl),
    .bootMode(bootMode), .parityEn(parityEn)
  );

  assign winOffset = addr[WIN_LOG2-1:0];
  assign mmuEnable = !bootMode;
endmodule

// File: tb/brd_boot_decoder_bench.sv
`timescale 1ns/1ps
module brd_boot_decoder_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busValid = 1'b0;
  logic        busWrite = 1'b0;
  logic [23:0] addr = '0;
  logic        wrLsb = 1'b0;
  logic [6:0]  irqReq = '0;
  logic [8:0]  selOut;
  logic        decodeMiss;
  logic [17:0] winOffset;
  logic [15:0] statusData;
  logic        bootMode, mmuEnable, parityEn;
  logic [6:0]  irqOut;

  always #2.5 clk = ~clk;

  brd_boot_decoder u_brd_boot_decoder (
    .clk(clk), .rstN(rstN), .busValid(busValid), .busWrite(busWrite),
    .addr(addr), .wrLsb(wrLsb), .irqReq(irqReq), .selOut(selOut),
    .decodeMiss(decodeMiss), .winOffset(winOffset), .statusData(statusData),
    .bootMode(bootMode), .mmuEnable(mmuEnable), .parityEn(parityEn),
    .irqOut(irqOut)
  );

  typedef struct {
    logic [8:0]  sel;
    logic        miss;
    logic [17:0] off;
    logic [15:0] stat;
    logic        boot;
    logic        mmu;
    logic        par;
    logic [6:0]  irq;
    string       tag;
  } item_t;

  item_t q[$];
  int checkCnt = 0;
  int failCnt  = 0;
  bit done = 1'b0;

  // reference model state
  logic       mBoot = 1'b1;
  logic       mPar  = 1'b0;
  logic [6:0] mPrev = '0;

  // -1 = miss, -2 = nothing selected
  function automatic int refIndex(logic v, logic w, logic [23:0] a, logic boot);
    if (!v) return -2;
    if (a < 24'h040000) return boot ? 1 : 0;
    if (a < 24'h200000) return -1;
    if (a < 24'h240000) return 1;
    if (a < 24'h400000) return -1;
    if (a < 24'h440000) return 2;
    if (a < 24'h600000) return -1;
    if (a < 24'h800000) return 3;
    if (a < 24'hA00000) return 4;
    if (a < 24'hC00000) return 5;
    if (a < 24'hE00000) return 6;
    return w ? 7 : 8;
  endfunction

  task automatic step(input logic v, input logic w, input logic [23:0] a,
                      input logic lsb, input logic [6:0] irq, input string tag);
    item_t e;
    int idx;
    @(negedge clk);
    busValid = v; busWrite = w; addr = a; wrLsb = lsb; irqReq = irq;
    idx = refIndex(v, w, a, mBoot);
    e.sel  = (idx >= 0) ? (9'd1 << idx) : 9'd0;
    e.miss = (idx == -1);
    e.off  = a[17:0];
    e.stat = (idx == 8) ? 16'h1FFF : 16'h0000;
    e.boot = mBoot;
    e.mmu  = !mBoot;
    e.par  = mPar;
    e.irq  = mBoot ? 7'd0 : mPrev;
    e.tag  = tag;
    q.push_back(e);
    if (v && w && a >= 24'h200000 && a < 24'h240000) begin
      mBoot = 1'b0;
      mPar  = lsb;
    end
    mPrev = irq;
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; busValid = 1'b0;
    repeat (2) @(negedge clk);
    mBoot = 1'b1; mPar = 1'b0; mPrev = '0;
    rstN = 1'b1;
  endtask

  // monitor: pops expected items and compares before the next rising edge
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (q.size() > 0) begin
        item_t e;
        e = q.pop_front();
        checkCnt++;
        if (selOut !== e.sel || decodeMiss !== e.miss || winOffset !== e.off ||
            statusData !== e.stat || bootMode !== e.boot || mmuEnable !== e.mmu ||
            parityEn !== e.par || irqOut !== e.irq) begin
          failCnt++;
          $display("FAIL %s: got sel=%h miss=%b off=%h stat=%h boot=%b mmu=%b par=%b irq=%h exp sel=%h miss=%b off=%h stat=%h boot=%b mmu=%b par=%b irq=%h",
                   e.tag, selOut, decodeMiss, winOffset, statusData, bootMode, mmuEnable,
                   parityEn, irqOut, e.sel, e.miss, e.off, e.stat, e.boot, e.mmu, e.par, e.irq);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checkCnt++; failCnt++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
      $finish;
    end
  end

  initial begin
    // R1 reset state seen during reset
    repeat (2) @(negedge clk);
    #1;
    checkCnt++;
    if (bootMode !== 1'b1 || parityEn !== 1'b0 || irqOut !== 7'd0 || mmuEnable !== 1'b0) begin
      failCnt++;
      $display("FAIL R1 in reset: got boot=%b par=%b irq=%h exp boot=1 par=0 irq=0",
               bootMode, parityEn, irqOut);
    end
    doReset();
    step(0, 0, 24'h000000, 0, 7'h00, "R1 after reset");
    step(0, 1, 24'h200000, 1, 7'h00, "R8 idle write to prom window");
    step(0, 0, 24'h000004, 0, 7'h00, "R8 idle no exit");
    step(1, 0, 24'h000010, 0, 7'h55, "R3 overlay low");
    step(1, 0, 24'h03C004, 0, 7'h55, "R3 overlay top / R12 offset");
    step(1, 1, 24'h000100, 1, 7'h55, "R10 overlay write");
    step(1, 0, 24'h000100, 0, 7'h55, "R10 boot kept / R11 held");
    step(1, 0, 24'h050000, 0, 7'h55, "R2 miss in boot");
    step(1, 0, 24'h200000, 0, 7'h55, "R4 prom0 base");
    step(1, 0, 24'h23FFFE, 0, 7'h55, "R4 prom0 top read no exit");
    step(1, 0, 24'h240000, 0, 7'h55, "R4 past prom0 window");
    step(1, 0, 24'h400002, 0, 7'h55, "R4 prom1");
    step(1, 0, 24'h5FFFFE, 0, 7'h55, "R4 past prom1 window");
    step(1, 0, 24'h600006, 0, 7'h55, "R5 serial");
    step(1, 1, 24'h7FFFF8, 0, 7'h55, "R5 serial mirror");
    step(1, 0, 24'h800002, 0, 7'h55, "R5 timer");
    step(1, 1, 24'h9ABCDE, 0, 7'h55, "R5 timer mirror");
    step(1, 0, 24'hA00000, 0, 7'h55, "R6 page map");
    step(1, 1, 24'hDFFFFE, 0, 7'h55, "R6 segment map");
    step(1, 0, 24'hE00000, 0, 7'h55, "R7 status read");
    step(1, 1, 24'hF12340, 0, 7'h55, "R7 context write");
    step(1, 0, 24'hFFFFFE, 0, 7'h55, "R7 status mirror");
    step(1, 1, 24'h200010, 1, 7'h55, "R9 exit write");
    step(0, 0, 24'h000000, 0, 7'h2A, "R9 exit / R11 pending released");
    step(1, 0, 24'h000010, 0, 7'h2A, "R2 ram / R11 follows");
    step(1, 1, 24'h03FFFE, 0, 7'h7F, "R2 ram top");
    step(1, 0, 24'h040000, 0, 7'h01, "R2 miss after boot");
    step(1, 1, 24'h230000, 0, 7'h01, "R9 parity clear write");
    step(1, 0, 24'h200000, 1, 7'h00, "R9 parity cleared");
    step(1, 0, 24'h23FFFE, 1, 7'h00, "R9 read leaves parity");
    step(1, 1, 24'h000020, 1, 7'h00, "R9 ram write no parity");
    step(1, 0, 24'h400000, 0, 7'h00, "R4 prom1 after boot");
    step(1, 0, 24'h1FFFFE, 0, 7'h00, "R2 miss top of low region");
    // reset again mid-run
    @(negedge clk); irqReq = 7'h33;
    doReset();
    step(1, 0, 24'h000010, 0, 7'h33, "R1 boot re-entered");
    step(0, 0, 24'h000000, 0, 7'h33, "R11 held after re-entry");
    step(1, 1, 24'h200000, 0, 7'h33, "R9 second exit");
    step(0, 0, 24'h000000, 0, 7'h00, "R11 release after second exit");
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
    $finish;
  end
endmodule